// File: doc/BRIEF.md
# Sampling Clock Divider with Phase Slip

This block divides a fast sampling clock by 1, 2 or 4. The ratio comes from a divide register or, when that register holds zero, from a two-bit pin selection. A register command moves the divided clock's rising edge one input-clock period earlier. Several converters that share one input clock can use this command to line up their divided clocks in a time-interleaved array.

The register-write port runs on the input clock. A write stores only the low bits that this block uses. A soft reset clears the divide counter and the slip command bit, but it leaves the chosen ratio in place. The block also outputs the divide counter, so that logic outside it can see the current phase.

Top module: `sampclk_divider`

## Requirements
- R1: While `rst_n` is low, the divide register, the slip bit and the counter are zero. After reset, the ratio comes from `pin_div`.
- R2: A write to address 0x72 stores data[2:0] in the divide register. The codes are 001 for divide by 1, 010 for divide by 2 and 100 for divide by 4. The new ratio takes effect one cycle after the write edge.
- R3: A write to 0x72 whose data[2:0] is neither zero nor one-hot leaves the divide register unchanged.
- R4: With the divide register at 000, `pin_div` selects the ratio: 00 gives divide by 1, 01 gives divide by 2, and 10 or 11 gives divide by 4.
- R5: In divide by 4, `clk_div` is high while the phase is 0 or 1 and low while it is 2 or 3. The phase steps by one on each input edge. In divide by 2, `clk_div` is high when phase bit 0 is zero.
- R6: In divide by 1, `clk_div` follows `clk_in`, the phase stays at 0, and a slip has no effect.
- R7: Bit 0 at address 0x71 is the slip bit. Writing 1 to it while it holds 0 advances the phase by one extra count. This happens on the edge one cycle after the write edge. Writing 1 while it already holds 1 does nothing.
- R8: Slips accumulate, each one moving the rising edge one input period earlier. In divide by 2, a slip inverts the output.
- R9: When the effective ratio changes, the phase returns to 0 on the next edge. From that edge, the output uses the new ratio.
- R10: `soft_rst` clears the phase and the slip bit and leaves the divide register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| pin_div | input | 2 | Pin ratio selection |
| clk_div | output | 1 | Divided clock |
| div_phase | output | 2 | Current divide counter |

## Verification
On every cycle, the assertions check the following:
- the divide register only ever holds a legal code;
- bad writes and soft resets leave the divide register alone;
- a ratio change zeroes the phase;
- divide by 1 keeps the phase at zero;
- a pending slip adds exactly two counts.

Only the bench's scenarios can show the following:
- that the whole output waveform matches the selected ratio;
- that the 0-then-1 write order is what fires a slip;
- that several slips move the edge cumulatively;
- that a soft reset re-arms the slip bit.

// File: rtl/sampclk_divider.sv
module sampclk_divider #(
  parameter logic [7:0] ADDR_SLIP = 8'h71,
  parameter logic [7:0] ADDR_DIV  = 8'h72
) (
  input  logic       clk_in,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] pin_div,
  output logic       clk_div,
  output logic [1:0] div_phase
);
  localparam logic [1:0] M1 = 2'd0, M2 = 2'd1, M4 = 2'd2;

  logic [2:0] div_sel;
  logic       slip_bit, slip_pend;
  logic [1:0] eff, eff_q, cnt;

  wire sel_ok    = (wr_data[2:0] & (wr_data[2:0] - 3'd1)) == 3'd0;
  wire div_wr    = wr_en && wr_addr == ADDR_DIV && sel_ok;
  wire slip_wr   = wr_en && wr_addr == ADDR_SLIP && !soft_rst;
  wire slip_fire = slip_wr && wr_data[0] && !slip_bit;

  always_comb begin
    if (div_sel == 3'd0)
      eff = (pin_div == 2'd0) ? M1 : (pin_div == 2'd1) ? M2 : M4;
    else
      eff = div_sel[0] ? M1 : div_sel[1] ? M2 : M4;
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)      div_sel <= 3'd0;
    else if (div_wr) div_sel <= wr_data[2:0];
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      slip_bit  <= 1'b0;
      slip_pend <= 1'b0;
    end else if (soft_rst) begin
      slip_bit  <= 1'b0;
      slip_pend <= 1'b0;
    end else begin
      if (slip_wr) slip_bit <= wr_data[0];
      slip_pend <= slip_fire;
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= 2'd0;
      eff_q <= M1;
    end else begin
      eff_q <= eff;
      if (soft_rst || eff != eff_q || eff == M1) cnt <= 2'd0;
      else cnt <= cnt + 2'd1 + {1'b0, slip_pend};
    end
  end

  assign clk_div   = (eff_q == M1) ? clk_in : (eff_q == M2) ? ~cnt[0] : ~cnt[1];
  assign div_phase = cnt;
endmodule

// File: rtl/sampclk_divider_chk.sv
module sampclk_divider_chk (
  input logic       clk_in,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [2:0] div_sel,
  input logic       slip_pend,
  input logic [1:0] eff,
  input logic [1:0] eff_q,
  input logic [1:0] cnt
);
  p_sel_legal_r3: assert property (@(posedge clk_in) disable iff (!rst_n)
    $onehot0(div_sel));

  p_bad_write_r3: assert property (@(posedge clk_in) disable iff (!rst_n)
    (wr_en && wr_addr == 8'h72 && !$onehot0(wr_data[2:0])) |=> $stable(div_sel));

  p_soft_keep_r10: assert property (@(posedge clk_in) disable iff (!rst_n)
    (soft_rst && !wr_en) |=> $stable(div_sel));

  p_soft_cnt_r10: assert property (@(posedge clk_in) disable iff (!rst_n)
    soft_rst |=> cnt == 2'd0);

  p_ratio_zero_r9: assert property (@(posedge clk_in) disable iff (!rst_n)
    (eff != eff_q) |=> cnt == 2'd0);

  p_div1_idle_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
    (eff == 2'd0 && eff_q == 2'd0) |=> cnt == 2'd0);

  p_slip_step_r7: assert property (@(posedge clk_in) disable iff (!rst_n)
    (slip_pend && !soft_rst && eff == 2'd2 && eff_q == 2'd2) |=> cnt == $past(cnt) + 2'd2);
endmodule

bind sampclk_divider sampclk_divider_chk u_chk (
  .clk_in(clk_in), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .div_sel(div_sel),
  .slip_pend(slip_pend), .eff(eff), .eff_q(eff_q), .cnt(cnt)
);

// File: tb/tb_sampclk_divider.sv
module tb_sampclk_divider;
  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic [1:0] pin_div = 2'd2;
  logic clk_div;
  logic [1:0] div_phase;
  int checks = 0, errors = 0;
  string tag = "R1";
  logic [2:0] exp_q[$];

  always #10 clk = ~clk;

  sampclk_divider dut (.clk_in(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pin_div(pin_div),
    .clk_div(clk_div), .div_phase(div_phase));

  // reference model built from the requirements; ratio: 1, 2 or 4
  int m_sel = 0, m_ratio_q = 1, m_phase = 0;
  bit m_slip = 0, m_pend = 0;

  function automatic int ratio_now();
    if (m_sel == 0) return (pin_div == 0) ? 1 : (pin_div == 1) ? 2 : 4;
    return (m_sel == 1) ? 1 : (m_sel == 2) ? 2 : 4;
  endfunction

  always @(posedge clk) begin
    int r, nsel, np;
    bit ns, npend, lvl;
    if (!rst_n) begin
      m_sel = 0; m_ratio_q = 1; m_phase = 0; m_slip = 0; m_pend = 0;
    end else begin
      r = ratio_now();
      nsel = m_sel; ns = m_slip; npend = 0;
      if (wr_en && wr_addr == 8'h72 && wr_data[2:0] inside {3'd0, 3'd1, 3'd2, 3'd4})
        nsel = wr_data[2:0];
      if (wr_en && wr_addr == 8'h71 && !soft_rst) begin
        npend = wr_data[0] && !m_slip;
        ns = wr_data[0];
      end
      if (soft_rst || r != m_ratio_q || r == 1) np = 0;
      else np = (m_phase + 1 + m_pend) % 4;
      if (soft_rst) begin ns = 0; npend = 0; end
      m_sel = nsel; m_slip = ns; m_pend = npend; m_ratio_q = r; m_phase = np;
    end
    lvl = (m_ratio_q == 1) ? 1'b0 : (m_ratio_q == 2) ? (m_phase % 2 == 0) : (m_phase < 2);
    exp_q.push_back({lvl, 2'(m_phase)});
  end

  always @(negedge clk) begin
    logic [2:0] e;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      checks++;
      if ({clk_div, div_phase} !== e) begin
        errors++;
        $display("FAIL %s: clk_div/phase actual %b/%0d expected %b/%0d",
                 tag, clk_div, div_phase, e[2], e[1:0]);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tag = "R1"; run(3);
    rst_n = 1'b1;
    tag = "R5"; run(10);
    tag = "R4"; pin_div = 2'd1; run(8);
    pin_div = 2'd3; run(8);
    tag = "R6"; pin_div = 2'd0; run(6);
    @(posedge clk); #5; checks++;
    if (clk_div !== 1'b1) begin
      errors++; $display("FAIL R6: clk_div high-phase actual %b expected 1", clk_div);
    end
    tag = "R2"; wr(8'h72, 8'h04); run(8);
    wr(8'h72, 8'h02); run(6);
    tag = "R3"; wr(8'h72, 8'h03); run(6);
    wr(8'h72, 8'hF7); run(6);
    tag = "R9"; wr(8'h72, 8'h04); run(6);
    tag = "R7"; wr(8'h71, 8'h00); wr(8'h71, 8'h01); run(8);
    wr(8'h71, 8'h01); run(8);
    tag = "R8"; wr(8'h71, 8'h00); wr(8'h71, 8'h01);
    wr(8'h71, 8'h00); wr(8'h71, 8'h01); run(8);
    wr(8'h72, 8'h02); run(4);
    wr(8'h71, 8'h00); wr(8'h71, 8'h01); run(6);
    tag = "R6"; wr(8'h72, 8'h01); wr(8'h71, 8'h00); wr(8'h71, 8'h01); run(6);
    tag = "R10"; wr(8'h72, 8'h04); pin_div = 2'd1; wr(8'h71, 8'h01); run(5);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    run(8);
    wr(8'h71, 8'h01); run(8);
    tag = "R1"; @(negedge clk); rst_n = 1'b0; run(3); rst_n = 1'b1; run(6);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule